// File: doc/BRIEF.md
# Hypercube Cube-Array Matrix Multiplier

This block multiplies two signed n x n integer matrices, with n = 2^Q, on a cube of n^3 processing elements. Every element holds an A operand, a B operand and a wide accumulator C. Element r sits at coordinates (i, j, k) with r = i*n^2 + j*n + k. Its top Q index bits give i, the middle Q bits give j and the low Q bits give k. An element exchanges data only with elements whose index differs from its own in one bit.

While idle, the host writes matrix element (row, col) of both operands into layer i = 0 and then pulses `start`. A fixed schedule follows, one clock per step. First, Q steps broadcast layer 0 to every layer. Next, Q steps spread A across the k dimensions so that element (i,j,k) holds a[j][i]. Then Q steps spread B across the j dimensions so that it holds b[i][k]. One step forms every product in parallel. Finally, Q steps add the products back down the i dimensions into layer 0. The host then reads product element (row, col) from a combinational read port.

Top module: `hcmm_top`

## Requirements
- R1: After reset `busy` and `done` are 0 and `rd_data` reads 0 at every (row, col).
- R2: While `busy` is 0, a cycle with `load_en` high stores `load_a` as A[row][col] and `load_b` as B[row][col], both signed W-bit two's complement, with row = `load_row` and col = `load_col`.
- R3: `start` high at a rising edge while `busy` is 0 sets `busy` from that edge on.
- R4: `done` is high for exactly one cycle, beginning 4Q+1 rising edges after the edge that accepted `start`. `busy` is 0 in that cycle and `done` is 0 in the cycle after it.
- R5: After `done`, `rd_data` for (row, col) equals the sum over t of A[row][t]*B[t][col], as a signed 2W+Q bit value.
- R6: Operands at the extremes of the signed W-bit range (all -2^(W-1), or -2^(W-1) against 2^(W-1)-1) give exact sums with no wrap.
- R7: `start` while `busy` is 1 is ignored. The run keeps its original `done` time and produces one `done` pulse.
- R8: `load_en` while `busy` is 1 is ignored and does not alter the result of the run in progress.
- R9: While idle, `rd_data` keeps the last result, and loading new operands does not change it until the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Write strobe for one operand pair |
| load_row | input | Q | Row of the element being written |
| load_col | input | Q | Column of the element being written |
| load_a | input | W | Signed element of the left operand |
| load_b | input | W | Signed element of the right operand |
| start | input | 1 | Begins a run when idle |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| rd_row | input | Q | Row of the product element to read |
| rd_col | input | Q | Column of the product element to read |
| rd_data | output | 2W+Q | Signed product element, combinational from rd_row/rd_col |

## Verification
The bench drives inputs and samples outputs on falling edges. It counts the falling edges after the edge that took `start` and expects `done` on exactly the (4Q+1)-th, with `busy` already high on the first. `done` is then checked low one edge later. For injected mid-run `start`, it is also checked low for a further 4Q+2 edges. The read port is combinational, so each product element is compared a short delay after `rd_row`/`rd_col` change, in the idle cycles after `done`. The expected values are plain row-by-column sums computed in the bench.

// File: rtl/hcmm_pkg.sv
package hcmm_pkg;

   // Operation applied by every element during one schedule step
   typedef enum logic [2:0] {
      OP_IDLE  = 3'd0,
      OP_BCAST = 3'd1,   // layer broadcast of A and B along an i dimension
      OP_SPRA  = 3'd2,   // spread A along a k dimension
      OP_SPRB  = 3'd3,   // spread B along a j dimension
      OP_MUL   = 3'd4,   // C = A * B in every element
      OP_RED   = 3'd5    // C += neighbour C along an i dimension
   } hc_op_e;

endpackage

// File: rtl/hcmm_seq.sv
module hcmm_seq
   import hcmm_pkg::*;
#(
   parameter int Q = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   output logic                         busy,
   output logic                         done,
   output hc_op_e                       op,
   output logic [$clog2(3*Q)-1:0]       dim
);
   localparam int D    = 3 * Q;
   localparam int DW   = $clog2(D);
   localparam int LAST = 4 * Q;
   localparam int STW  = $clog2(LAST + 2);

   logic [STW-1:0] step_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         step_q <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy   <= 1'b1;
               step_q <= '0;
            end
         end else if (int'(step_q) == LAST) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else begin
            step_q <= step_q + 1'b1;
         end
      end
   end

   // Step number to operation and dimension
   always_comb begin
      int s;
      s   = int'(step_q);
      op  = OP_IDLE;
      dim = '0;
      if (busy) begin
         if (s < Q) begin
            op  = OP_BCAST;
            dim = DW'(D - 1 - s);
         end else if (s < 2 * Q) begin
            op  = OP_SPRA;
            dim = DW'(2 * Q - 1 - s);
         end else if (s < 3 * Q) begin
            op  = OP_SPRB;
            dim = DW'(4 * Q - 1 - s);
         end else if (s == 3 * Q) begin
            op  = OP_MUL;
         end else begin
            op  = OP_RED;
            dim = DW'(s - Q - 1);
         end
      end
   end

endmodule

// File: rtl/hcmm_pe.sv
module hcmm_pe
   import hcmm_pkg::*;
#(
   parameter int Q   = 2,
   parameter int W   = 8,
   parameter int IDX = 0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  hc_op_e                       op,
   input  logic [$clog2(3*Q)-1:0]       dim,
   input  logic                         ld_en,
   input  logic [2*Q-1:0]               ld_idx,
   input  logic signed [W-1:0]          ld_a,
   input  logic signed [W-1:0]          ld_b,
   input  logic signed [W-1:0]          nbr_a [3*Q],
   input  logic signed [W-1:0]          nbr_b [3*Q],
   input  logic signed [2*W+Q-1:0]      nbr_c [3*Q],
   output logic signed [W-1:0]          a_o,
   output logic signed [W-1:0]          b_o,
   output logic signed [2*W+Q-1:0]      c_o
);
   localparam int D  = 3 * Q;
   localparam int DW = $clog2(D);
   localparam int CW = 2 * W + Q;
   localparam bit IN_L0 = IDX < (1 << (2 * Q));
   localparam logic [2*Q-1:0] MY_L0 = (2*Q)'(IDX);

   // Per-dimension receive masks, fixed by this element's index
   function automatic logic [D-1:0] rx_mask(input int kind);
      logic [D-1:0] m;
      m = '0;
      for (int d = 0; d < D; d++) begin
         int bd;
         bd = (IDX >> d) & 1;
         case (kind)
            0:       m[d] = (d >= 2 * Q) && (bd == 1);
            1:       m[d] = (d < Q) && (bd != ((IDX >> (d + 2 * Q)) & 1));
            2:       m[d] = (d >= Q) && (d < 2 * Q) && (bd != ((IDX >> (d + Q)) & 1));
            default: m[d] = (d >= 2 * Q) && (bd == 0);
         endcase
      end
      return m;
   endfunction

   localparam logic [D-1:0] RX_BC  = rx_mask(0);
   localparam logic [D-1:0] RX_A   = rx_mask(1);
   localparam logic [D-1:0] RX_B   = rx_mask(2);
   localparam logic [D-1:0] RX_RED = rx_mask(3);

   logic signed [W-1:0]  a_q, b_q;
   logic signed [CW-1:0] c_q;
   logic signed [CW-1:0] a_x, b_x;
   logic [DW-1:0]        ds;
   logic                 ld_hit;

   assign ds     = (int'(dim) < D) ? dim : '0;
   assign a_x    = a_q;
   assign b_x    = b_q;
   assign ld_hit = IN_L0 && ld_en && (ld_idx == MY_L0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
         c_q <= '0;
      end else begin
         if (ld_hit) begin
            a_q <= ld_a;
            b_q <= ld_b;
         end
         case (op)
            OP_BCAST: if (RX_BC[ds]) begin
               a_q <= nbr_a[ds];
               b_q <= nbr_b[ds];
            end
            OP_SPRA:  if (RX_A[ds]) a_q <= nbr_a[ds];
            OP_SPRB:  if (RX_B[ds]) b_q <= nbr_b[ds];
            OP_MUL:   c_q <= a_x * b_x;
            OP_RED:   if (RX_RED[ds]) c_q <= c_q + nbr_c[ds];
            default:  ;
         endcase
      end
   end

   assign a_o = a_q;
   assign b_o = b_q;
   assign c_o = c_q;

endmodule

// File: rtl/hcmm_top.sv
module hcmm_top
   import hcmm_pkg::*;
#(
   parameter int Q = 2,
   parameter int W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load_en,
   input  logic [Q-1:0]            load_row,
   input  logic [Q-1:0]            load_col,
   input  logic [W-1:0]            load_a,
   input  logic [W-1:0]            load_b,
   input  logic                    start,
   output logic                    busy,
   output logic                    done,
   input  logic [Q-1:0]            rd_row,
   input  logic [Q-1:0]            rd_col,
   output logic [2*W+Q-1:0]        rd_data
);
   localparam int N   = 1 << Q;
   localparam int D   = 3 * Q;
   localparam int NPE = N * N * N;
   localparam int CW  = 2 * W + Q;
   localparam int DW  = $clog2(D);

   if (Q < 1 || Q > 3) begin : g_bad_q
      $error("hcmm_top: Q must lie in 1..3");
   end
   if (W < 2) begin : g_bad_w
      $error("hcmm_top: W must be at least 2");
   end

   hc_op_e          op;
   logic [DW-1:0]   dim;

   hcmm_seq #(.Q(Q)) seq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (busy),
      .done  (done),
      .op    (op),
      .dim   (dim)
   );

   logic signed [W-1:0]  a_all [NPE];
   logic signed [W-1:0]  b_all [NPE];
   logic signed [CW-1:0] c_all [NPE];
   logic signed [W-1:0]  nb_a  [NPE][D];
   logic signed [W-1:0]  nb_b  [NPE][D];
   logic signed [CW-1:0] nb_c  [NPE][D];

   logic           ld_en;
   logic [2*Q-1:0] ld_idx;

   assign ld_en  = load_en && !busy;
   assign ld_idx = {load_row, load_col};

   for (genvar r = 0; r < NPE; r++) begin : g_pe
      for (genvar d = 0; d < D; d++) begin : g_link
         assign nb_a[r][d] = a_all[r ^ (1 << d)];
         assign nb_b[r][d] = b_all[r ^ (1 << d)];
         assign nb_c[r][d] = c_all[r ^ (1 << d)];
      end

      hcmm_pe #(.Q(Q), .W(W), .IDX(r)) pe_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .op     (op),
         .dim    (dim),
         .ld_en  (ld_en),
         .ld_idx (ld_idx),
         .ld_a   (load_a),
         .ld_b   (load_b),
         .nbr_a  (nb_a[r]),
         .nbr_b  (nb_b[r]),
         .nbr_c  (nb_c[r]),
         .a_o    (a_all[r]),
         .b_o    (b_all[r]),
         .c_o    (c_all[r])
      );
   end

   assign rd_data = c_all[{{Q{1'b0}}, rd_row, rd_col}];

endmodule

// File: rtl/hcmm_chk.sv
module hcmm_chk #(
   parameter int Q = 2,
   parameter int W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               busy,
   input logic               done,
   input logic [Q-1:0]       rd_row,
   input logic [Q-1:0]       rd_col,
   input logic [2*W+Q-1:0]   rd_data
);
   localparam int RUN = 4 * Q + 1;

   int unsigned busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_cnt <= 0;
      else        busy_cnt <= busy ? busy_cnt + 1 : 0;
   end

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                    // R4
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);                                                    // R4
   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy_cnt == RUN);                                          // R4
   AST_RUN_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));                                      // R3
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && busy_cnt < RUN - 1) |=> busy);                    // R7
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !done && !$past(busy) && $stable(rd_row) && $stable(rd_col))
      |-> $stable(rd_data));                                              // R9

endmodule

bind hcmm_top hcmm_chk #(.Q(Q), .W(W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .rd_row  (rd_row),
   .rd_col  (rd_col),
   .rd_data (rd_data)
);

// File: tb/hcmm_top_tb_top.sv
`timescale 1ns/1ps
module hcmm_top_tb_top;
   localparam int Q  = 2;
   localparam int W  = 8;
   localparam int N  = 1 << Q;
   localparam int CW = 2 * W + Q;
   localparam int RUN = 4 * Q + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic load_en = 1'b0;
   logic [Q-1:0] load_row = '0, load_col = '0;
   logic [W-1:0] load_a = '0, load_b = '0;
   logic start = 1'b0;
   logic busy, done;
   logic [Q-1:0] rd_row = '0, rd_col = '0;
   logic [CW-1:0] rd_data;

   always #2 clk = ~clk;   // 250 MHz

   hcmm_top #(.Q(Q), .W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_row(load_row),
      .load_col(load_col), .load_a(load_a), .load_b(load_b), .start(start),
      .busy(busy), .done(done), .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
   );

   int checks = 0;
   int errors = 0;
   int ma [N][N];
   int mb [N][N];
   int res [N][N];
   logic [31:0] lfsr = 32'h1ACE_B00C;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int to_w(input int v);
      logic [W-1:0] t;
      t = W'(v);
      return int'($signed(t));
   endfunction

   task automatic next_rand(output int v);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      v = to_w(int'(lfsr[W-1:0]));
   endtask

   // kind 0 identity x counting, 1 random, 2 all min, 3 min x max, 4 small example
   task automatic fill(input int kind);
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) begin
            int x, y;
            case (kind)
               0: begin x = (r == c) ? 1 : 0; y = to_w(r * N + c - 8); end
               1: begin next_rand(x); next_rand(y); end
               2: begin x = -(1 << (W - 1)); y = -(1 << (W - 1)); end
               3: begin x = -(1 << (W - 1)); y = (1 << (W - 1)) - 1; end
               default: begin x = r * N + c + 1; y = -(r * N + c + 1); end
            endcase
            ma[r][c] = x;
            mb[r][c] = y;
         end
   endtask

   task automatic compute_exp();
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) begin
            int s;
            s = 0;
            for (int t = 0; t < N; t++) s += ma[r][t] * mb[t][c];
            res[r][c] = s;
         end
   endtask

   task automatic load_all();
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) begin
            @(negedge clk);
            load_en  = 1'b1;
            load_row = Q'(r);
            load_col = Q'(c);
            load_a   = W'(ma[r][c]);
            load_b   = W'(mb[r][c]);
         end
      @(negedge clk);
      load_en = 1'b0;
   endtask

   task automatic check_results(input string tag);
      for (int r = 0; r < N; r++)
         for (int c = 0; c < N; c++) begin
            rd_row = Q'(r);
            rd_col = Q'(c);
            #0.5;
            chk(int'($signed(rd_data)) == res[r][c], tag,
                int'($signed(rd_data)), res[r][c]);
         end
   endtask

   task automatic do_run(input bit inject);
      int k;
      bit seen;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R3 busy after start", int'(busy), 1);
      k = 0;
      seen = 1'b0;
      while (!seen && k < 100) begin
         @(negedge clk);
         k++;
         if (inject && k == 3) begin
            start = 1'b1;                 // R7 stimulus
            load_en = 1'b1;               // R8 stimulus
            load_row = '0;
            load_col = '0;
            load_a = W'(55);
            load_b = W'(-9);
         end else begin
            start = 1'b0;
            load_en = 1'b0;
         end
         if (done) seen = 1'b1;
      end
      chk(seen && k == RUN, inject ? "R7 done time with mid-run start" : "R4 done latency", k, RUN);
      chk(busy == 1'b0, "R4 busy low at done", int'(busy), 0);
      @(negedge clk);
      start = 1'b0;
      load_en = 1'b0;
      chk(done == 1'b0, "R4 done single cycle", int'(done), 0);
      if (inject) begin
         int extra;
         extra = 0;
         for (int i = 0; i < RUN + 1; i++) begin
            @(negedge clk);
            if (done || busy) extra++;
         end
         chk(extra == 0, "R7 no second run", extra, 0);
      end
   endtask

   initial begin : watchdog
      int cyc;
      cyc = 0;
      while (!finished) begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
      chk(done == 1'b0, "R1 done after reset", int'(done), 0);
      for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) res[r][c] = 0;
      check_results("R1 read zero after reset");

      // R2/R5 identity times counting matrix
      fill(0); compute_exp(); load_all(); do_run(1'b0);
      check_results("R2 R5 identity pattern");

      // R5 small signed example
      fill(4); compute_exp(); load_all(); do_run(1'b0);
      check_results("R5 signed sequence");

      // R5 random sweep
      for (int p = 0; p < 12; p++) begin
         fill(1); compute_exp(); load_all(); do_run(1'b0);
         check_results("R5 random operands");
      end

      // R6 extremes
      fill(2); compute_exp(); load_all(); do_run(1'b0);
      check_results("R6 all minimum");
      fill(3); compute_exp(); load_all(); do_run(1'b0);
      check_results("R6 minimum times maximum");

      // R7/R8 start and load during a run
      fill(1); compute_exp(); load_all(); do_run(1'b1);
      check_results("R8 load during run ignored");

      // R9 new operands loaded while idle leave the result untouched
      begin
         int keep [N][N];
         keep = res;
         fill(1); load_all();
         res = keep;
         repeat (2) @(negedge clk);
         check_results("R9 result held across idle load");
         compute_exp(); do_run(1'b0);
         check_results("R9 R5 next run uses new operands");
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule